// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switch with Power-of-Two Prescaler

This block produces the system clock from one of eight free-running source clocks and divides it by a selectable power of two. A single 32-bit control word is written from a configuration clock domain. It holds three things: the index of the wanted source, the prescaler exponent, and one enable bit per source. The same word reads back the selection, a switch-complete flag, and the synchronised ready signals of all eight oscillators. The oscillators themselves are outside the block. Each one appears only as a clock input and a ready input.

Moving to another source is a handshake across clock domains. The block first checks that the target is both enabled and ready. It then gates the current source off on that source's low phase. It waits until that gate-off has been seen back in the configuration domain, and only then gates the target on during the target's low phase. The switch-complete flag stays low until the target's gate has been seen as open. A change of the prescaler exponent waits for the end of a divided period. No output pulse is ever made shorter than a phase of the source that drives it.

Top module: `sysclk_switch`

## Requirements
- R1: After reset the selection is source 0 with exponent 0 and only the enable of source 0 set. The control word then reads 0xFF012000 with all oscillators ready, and the output period equals that of source 0.
- R2: The source index is at bits 11:9. Once a switch completes at exponent 0, the output period equals the period of the selected source.
- R3: The exponent n is at bits 8:6. The output period equals the source period times 2^n, for every n from 0 to 7.
- R4: Bit 13 reads 0 while the switch to a newly selected source is still pending, and 1 once the output runs from that source.
- R5: Each source has an enable bit at 16+i (1 = enabled). Selecting a disabled source leaves the output on the previous source and keeps bit 13 at 0.
- R6: Selecting a source whose ready input is low leaves the output on the previous source with bit 13 at 0. The switch completes after that ready input rises.
- R7: Bits 31:24 read back the eight oscillator ready inputs, bit 24+i for source i, after a two-flop synchroniser.
- R8: No high or low phase of the output is shorter than the shortest half period among the sources. This holds across source switches.
- R9: Writes to the read-only bits (31:24, 15:12, 5:0) have no effect, and those bits other than 31:24 and 13 always read 0.
- R10: A new exponent takes effect only at the end of a divided period. Moving from divide-by-128 to divide-by-1 produces no short pulse and then yields the undivided period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock for the control word |
| rst | input | 1 | Synchronous active-high reset in the cfg_clk domain |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Registered control word read value |
| src_clk | input | 8 | Source clocks, bit i is source i |
| osc_rdy | input | 8 | Oscillator ready inputs, bit i for source i |
| sys_clk_o | output | 1 | Selected and divided system clock |

## Verification
The hardest case to reach from the ports is a switch that is refused or held off while the output keeps running. The bench reaches it in two ways. In the first it clears the target's enable bit in the same write that selects the target. In the second it drops the target's ready input before the write and raises it again later. In both cases it measures the output period and reads back bit 13 while the request is pending. A pulse-width monitor runs for the whole test and catches any shortened phase. This covers every switch and a move from divide-by-128 to divide-by-1 made while the slowest divided clock is running.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
  // bit positions inside the control word
  localparam int DIV_LSB  = 6;
  localparam int SEL_LSB  = 9;
  localparam int DONE_BIT = 13;
  localparam int EN_LSB   = 16;
  localparam int ORDY_LSB = 24;
  localparam int WORD_W   = 32;
endpackage

// File: rtl/sysclk_ctrl_regs.sv
`timescale 1ns/1ps
module sysclk_ctrl_regs
  import sysclk_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int SEL_W = $clog2(NSRC),
  parameter int DIV_W = 3
) (
  input  logic              cfg_clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NSRC-1:0]   osc_rdy,
  input  logic              sw_done,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [NSRC-1:0]   en_o,
  output logic [NSRC-1:0]   rdy_s_o,
  output logic [WORD_W-1:0] rd_data
);
  logic [NSRC-1:0]   rdy_m, rdy_s;
  logic [SEL_W-1:0]  sel_q;
  logic [DIV_W-1:0]  div_q;
  logic [NSRC-1:0]   en_q;
  logic [WORD_W-1:0] rd_w;

  // oscillator ready inputs cross into the configuration domain
  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      rdy_m <= '0;
      rdy_s <= '0;
    end else begin
      rdy_m <= osc_rdy;
      rdy_s <= rdy_m;
    end
  end

  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      sel_q <= '0;
      div_q <= '0;
      en_q  <= NSRC'(1);
    end else if (wr_en) begin
      sel_q <= wr_data[SEL_LSB +: SEL_W];
      div_q <= wr_data[DIV_LSB +: DIV_W];
      en_q  <= wr_data[EN_LSB +: NSRC];
    end
  end

  always_comb begin
    rd_w = '0;
    rd_w[DIV_LSB +: DIV_W]  = div_q;
    rd_w[SEL_LSB +: SEL_W]  = sel_q;
    rd_w[DONE_BIT]          = sw_done;
    rd_w[EN_LSB +: NSRC]    = en_q;
    rd_w[ORDY_LSB +: NSRC]  = rdy_s;
  end

  always_ff @(posedge cfg_clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_w;
  end

  assign sel_o   = sel_q;
  assign div_o   = div_q;
  assign en_o    = en_q;
  assign rdy_s_o = rdy_s;

  // R2
  sel_write_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    wr_en |=> sel_q == $past(wr_data[SEL_LSB +: SEL_W]));

  // R9
  hold_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    !wr_en |=> $stable(sel_q) && $stable(div_q) && $stable(en_q));
endmodule

// File: rtl/sysclk_src_sel.sv
`timescale 1ns/1ps
module sysclk_src_sel #(
  parameter int NSRC  = 8,
  parameter int SEL_W = $clog2(NSRC)
) (
  input  logic             cfg_clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_clk,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  en,
  input  logic [NSRC-1:0]  rdy_s,
  output logic             mclk_o,
  output logic             done_o
);
  logic [NSRC-1:0] tgt_oh;
  logic [NSRC-1:0] grant_q;
  logic [NSRC-1:0] gate_vec;
  logic [NSRC-1:0] fb_m, fb_s;
  logic            eligible;
  logic            settled;

  always_comb begin
    tgt_oh   = NSRC'(1) << sel;
    eligible = en[sel] & rdy_s[sel];
    settled  = (fb_s == grant_q);
  end

  // grant only moves once the gates have caught up with the previous grant
  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      grant_q <= NSRC'(1);
    end else if (settled && eligible && (grant_q != tgt_oh)) begin
      if (grant_q != '0) grant_q <= '0;
      else               grant_q <= tgt_oh;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic rs_m, rs_s;
    logic req_m, req_s;
    logic gate_q;

    always_ff @(posedge src_clk[g]) begin
      rs_m <= rst;
      rs_s <= rs_m;
    end

    always_ff @(posedge src_clk[g]) begin
      if (rs_s) begin
        req_m <= (g == 0);
        req_s <= (g == 0);
      end else begin
        req_m <= grant_q[g];
        req_s <= req_m;
      end
    end

    // the gate changes only while this source is low
    always_ff @(negedge src_clk[g]) begin
      if (rs_s) gate_q <= (g == 0);
      else      gate_q <= req_s;
    end

    assign gate_vec[g] = gate_q;
  end

  always_comb mclk_o = |(src_clk & gate_vec);

  always_ff @(posedge cfg_clk) begin
    if (rst) begin
      fb_m <= NSRC'(1);
      fb_s <= NSRC'(1);
    end else begin
      fb_m <= gate_vec;
      fb_s <= fb_m;
    end
  end

  always_comb done_o = (grant_q == tgt_oh) && (fb_s == tgt_oh);

  // R8
  one_gate_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    $onehot0(fb_s));

  // R8
  one_grant_chk: assert property (@(posedge cfg_clk) disable iff (rst)
    $onehot0(grant_q));
endmodule

// File: rtl/sysclk_prescaler.sv
`timescale 1ns/1ps
module sysclk_prescaler #(
  parameter int DIV_W = 3
) (
  input  logic             mclk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_req,
  output logic             sys_clk_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic             rs_m, rs_s;
  logic [DIV_W-1:0] d_m, d_s, d_h;
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic [CNT_W:0]   lim_wide;
  logic             pass_q;

  always_ff @(posedge mclk) begin
    rs_m <= rst;
    rs_s <= rs_m;
  end

  // exponent crosses over; accepted only once two samples agree
  always_ff @(posedge mclk) begin
    if (rs_s) begin
      d_m <= '0;
      d_s <= '0;
      d_h <= '0;
    end else begin
      d_m <= div_req;
      d_s <= d_m;
      d_h <= d_s;
    end
  end

  always_comb lim_wide = ({{CNT_W{1'b0}}, 1'b1} << d_h) - 1'b1;

  always_ff @(posedge mclk) begin
    if (rs_s) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (cnt_q == lim_q) begin
      cnt_q <= '0;
      if (d_s == d_h) lim_q <= lim_wide[CNT_W-1:0];
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // pulse enable settles during the low phase of the master clock
  always_ff @(negedge mclk) begin
    if (rs_s) pass_q <= 1'b1;
    else      pass_q <= (cnt_q == '0);
  end

  always_comb sys_clk_o = mclk & pass_q;

  // R3
  cnt_range_chk: assert property (@(posedge mclk) disable iff (rs_s)
    cnt_q <= lim_q);

  // R10
  div_boundary_chk: assert property (@(posedge mclk) disable iff (rs_s)
    (lim_q != $past(lim_q)) |-> ($past(cnt_q) == $past(lim_q)));
endmodule

// File: rtl/sysclk_switch.sv
`timescale 1ns/1ps
module sysclk_switch
  import sysclk_pkg::*;
#(
  parameter int NSRC  = 8,
  parameter int DIV_W = 3
) (
  input  logic              cfg_clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NSRC-1:0]   src_clk,
  input  logic [NSRC-1:0]   osc_rdy,
  output logic              sys_clk_o
);
  localparam int SEL_W = $clog2(NSRC);

  logic [SEL_W-1:0] sel;
  logic [DIV_W-1:0] div;
  logic [NSRC-1:0]  en;
  logic [NSRC-1:0]  rdy_s;
  logic             done;
  logic             mclk;

  sysclk_ctrl_regs #(.NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_regs (
    .cfg_clk (cfg_clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .osc_rdy (osc_rdy),
    .sw_done (done),
    .sel_o   (sel),
    .div_o   (div),
    .en_o    (en),
    .rdy_s_o (rdy_s),
    .rd_data (rd_data)
  );

  sysclk_src_sel #(.NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
    .cfg_clk (cfg_clk),
    .rst     (rst),
    .src_clk (src_clk),
    .sel     (sel),
    .en      (en),
    .rdy_s   (rdy_s),
    .mclk_o  (mclk),
    .done_o  (done)
  );

  sysclk_prescaler #(.DIV_W(DIV_W)) u_div (
    .mclk      (mclk),
    .rst       (rst),
    .div_req   (div),
    .sys_clk_o (sys_clk_o)
  );
endmodule

// File: tb/sysclk_switch_test.sv
`timescale 1ns/1ps
module sysclk_switch_test;
  logic        cfg_clk = 0;
  logic        rst = 1;
  logic        wr_en = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_clk;
  logic [7:0]  osc_rdy = 8'hFF;
  logic        sys_clk_o;

  int n_chk = 0;
  int n_fail = 0;
  int glitches = 0;
  bit mon_on = 0;
  realtime t_rise = 0, t_fall = 0;
  bit seen_rise = 0, seen_fall = 0;

  always #5 cfg_clk = ~cfg_clk;

  // source i has half period 4+i ns
  for (genvar g = 0; g < 8; g++) begin : g_clk
    initial begin
      src_clk[g] = 1'b0;
      forever #(4 + g) src_clk[g] = ~src_clk[g];
    end
  end

  sysclk_switch uut (
    .cfg_clk(cfg_clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_clk(src_clk), .osc_rdy(osc_rdy),
    .sys_clk_o(sys_clk_o)
  );

  // phase-width monitor for R8 and R10
  always @(posedge sys_clk_o) begin
    if (mon_on && seen_fall && ($realtime - t_fall) < 3.5) glitches++;
    t_rise = $realtime; seen_rise = 1;
  end
  always @(negedge sys_clk_o) begin
    if (mon_on && seen_rise && ($realtime - t_rise) < 3.5) glitches++;
    t_fall = $realtime; seen_fall = 1;
  end

  // {source, exponent}
  localparam logic [5:0] VEC [8] = '{
    {3'd0, 3'd0}, {3'd3, 3'd0}, {3'd7, 3'd0}, {3'd2, 3'd1},
    {3'd5, 3'd3}, {3'd1, 3'd7}, {3'd6, 3'd2}, {3'd4, 3'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge cfg_clk);
    wr_en = 1; wr_data = d;
    @(negedge cfg_clk);
    wr_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge cfg_clk);
  endtask

  task automatic period(output int p);
    realtime t0;
    @(posedge sys_clk_o);
    t0 = $realtime;
    @(posedge sys_clk_o);
    p = int'($realtime - t0);
  endtask

  function automatic logic [31:0] word(input int s, input int d, input logic [7:0] en);
    return (32'(en) << 16) | (32'(s) << 9) | (32'(d) << 6);
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int p;
    wait_cyc(20);
    rst = 0;
    wait_cyc(10);
    mon_on = 1;
    // R1 reset state
    chk("R1 reset word", rd_data, 32'hFF01_2000);
    period(p);
    chk("R1 reset period", 32'(p), 32'd8);

    // R2/R3/R4 vector walk
    for (int i = 0; i < 8; i++) begin
      int s, d;
      s = int'(VEC[i][5:3]);
      d = int'(VEC[i][2:0]);
      wr(word(s, d, 8'hFF));
      wait_cyc(700);
      chk("R4 switch done", 32'(rd_data[13]), 32'd1);
      chk("R2 sel readback", 32'(rd_data[11:9]), 32'(s));
      period(p);
      chk("R3 period", 32'(p), 32'((2 * (4 + s)) << d));
    end

    // R5 disabled target: on source 4 now
    wr(word(4, 0, 8'hFF));
    wait_cyc(700);
    wr(word(6, 0, 8'hBF));
    wait_cyc(200);
    chk("R5 stays pending", 32'(rd_data[13]), 32'd0);
    period(p);
    chk("R5 old source kept", 32'(p), 32'd16);

    // R6 target not ready
    osc_rdy = 8'hFB;
    wr(word(2, 0, 8'hFF));
    wait_cyc(200);
    chk("R6 stays pending", 32'(rd_data[13]), 32'd0);
    period(p);
    chk("R6 old source kept", 32'(p), 32'd16);
    osc_rdy = 8'hFF;
    wait_cyc(2);
    chk("R4 not yet done", 32'(rd_data[13]), 32'd0);
    wait_cyc(200);
    chk("R6 switch after ready", 32'(rd_data[13]), 32'd1);
    period(p);
    chk("R6 new period", 32'(p), 32'd12);

    // R7 ready readback
    osc_rdy = 8'hA5;
    wait_cyc(5);
    chk("R7 ready bits", 32'(rd_data[31:24]), 32'hA5);
    osc_rdy = 8'hFF;
    wait_cyc(5);

    // R9 read-only bits written
    wr(32'hFFFF_F03F);
    wait_cyc(200);
    chk("R9 ro ignored", rd_data, 32'hFFFF_2000);
    period(p);
    chk("R9 period src0", 32'(p), 32'd8);

    // R10 divider change mid-run, slowest case
    wr(word(7, 7, 8'hFF));
    wait_cyc(800);
    period(p);
    chk("R10 div128", 32'(p), 32'd2816);
    wait_cyc(37);
    wr(word(7, 0, 8'hFF));
    wait_cyc(800);
    period(p);
    chk("R10 div1", 32'(p), 32'd22);

    // R8 no short phase anywhere in the run
    chk("R8 glitch count", 32'(glitches), 32'd0);
    summary();
  end
endmodule